// File: doc/BRIEF.md
# Dual-Rail Minterm Gate

This block evaluates an arbitrary Boolean function of a few dual-rail inputs and produces one dual-rail result. Each logical input bit uses two wires: a true rail and a false rail. For every possible input combination (minterm) there is one Muller C-element. That C-element watches one rail per input: the true rail where the minterm has a 1, the false rail where it has a 0. The minterm cells are split into two OR trees at elaboration according to a truth-table parameter. One tree drives the output true rail and the other drives the output false rail.

Because every minterm cell holds its value, the output behaves in a delay-insensitive way. It leaves the spacer state only once every input bit carries valid data. It goes back to spacer only once every input has returned to spacer. Each C-element is modelled as a storage bit that is re-evaluated on `clk`. It rises when all of its watched rails are high, falls when all of them are low, and otherwise keeps its value. An asynchronous active-low reset clears all cells so that simulation begins in spacer. Handshake and acknowledge logic are left to the surrounding pipeline.

Top module: `dr_minterm_gate`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released with all inputs in spacer, both output rails are 0.
- R2: Input bit i is encoded as follows. in_t[i]=1 with in_f[i]=0 means logic 1. in_t[i]=0 with in_f[i]=1 means logic 0. Both rails 0 is spacer. Both rails 1 is illegal and is never expected.
- R3: When all inputs become valid, one clock edge later the output is valid. With k = sum of in_t[i]<<i, out_t equals TRUTH[k] and out_f equals its complement.
- R4: out_t and out_f are never both 1.
- R5: While at least one input bit is still spacer, an output that was in spacer stays in spacer.
- R6: Once the output is valid, it keeps its value while only some inputs have returned to spacer. It returns to spacer one clock edge after every input is spacer.
- R7: The truth table is a parameter of width 2^N_IN and sets the function. A 2-input instance with TRUTH=4'b0110 computes XOR. A 3-input instance with TRUTH=8'b11101000 computes majority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation strobe for the C-element state |
| rst_n | input | 1 | Asynchronous active-low reset, clears all minterm cells |
| in_t | input | N_IN | True rails of the input bits |
| in_f | input | N_IN | False rails of the input bits |
| out_t | output | 1 | True rail of the result |
| out_f | output | 1 | False rail of the result |

## Verification
A minterm cell stuck high or set wrongly can show up in three ways. The output may leave spacer during a partly valid phase, it may fail to return to spacer after a full spacer phase, or both rails may be raised at once. Each of these appears at the ports within one clock edge of the phase that exposes it. A misrouted truth-table bit appears as a wrong output rail on the first valid phase of that input combination. A cell that fails to hold appears as an early return to spacer during a partly cleared phase. The sweep drives every combination through partly valid, valid, partly cleared and spacer phases, so each of these faults is seen on the pattern that triggers it.

// File: rtl/dr_minterm_gate.sv
module dr_minterm_gate #(
  parameter int N_IN = 3,
  parameter logic [2**N_IN-1:0] TRUTH = 8'b1110_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_t,
  input  logic [N_IN-1:0] in_f,
  output logic            out_t,
  output logic            out_f
);
  localparam int NTERM = 2**N_IN;

  logic [NTERM-1:0] cel_q;

  for (genvar m = 0; m < NTERM; m++) begin : g_term
    logic [N_IN-1:0] pick;
    for (genvar i = 0; i < N_IN; i++) begin : g_rail
      if (((m >> i) % 2) == 1) begin : g_hi
        assign pick[i] = in_t[i];
      end else begin : g_lo
        assign pick[i] = in_f[i];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cel_q[m] <= 1'b0;
      else if (&pick)      cel_q[m] <= 1'b1;
      else if (~|pick)     cel_q[m] <= 1'b0;
    end
  end

  assign out_t = |(cel_q & TRUTH);
  assign out_f = |(cel_q & ~TRUTH);

  logic all_valid, all_null, out_any;
  assign all_valid = &(in_t ^ in_f);
  assign all_null  = ~|(in_t | in_f);
  assign out_any   = out_t | out_f;

  assert_no_illegal_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ~|(in_t & in_f));
  assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_t && out_f));
  assert_one_minterm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cel_q));
  assert_wait_all_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_any && !all_valid) |=> !out_any);
  assert_hold_until_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_any && !all_null) |=> (out_any && $stable(out_t)));
  assert_clear_on_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    all_null |=> !out_any);
  assert_table_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_any && all_valid) |=> (out_t == TRUTH[$past(in_t)]));
endmodule

// File: tb/sim_dr_minterm_gate.sv
module sim_dr_minterm_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] in_t = '0, in_f = '0;
  logic o3_t, o3_f, o2_t, o2_f;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dr_minterm_gate #(.N_IN(3), .TRUTH(8'b1110_1000)) u0 (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .out_t(o3_t), .out_f(o3_f));
  dr_minterm_gate #(.N_IN(2), .TRUTH(4'b0110)) u1 (
    .clk(clk), .rst_n(rst_n), .in_t(in_t[1:0]), .in_f(in_f[1:0]), .out_t(o2_t), .out_f(o2_f));

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got t/f=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check("R1 in reset u0", {o3_t, o3_f}, 2'b00);
    check("R1 in reset u1", {o2_t, o2_f}, 2'b00);
    step();
    rst_n = 1'b1;
    step();
    check("R1 after reset u0", {o3_t, o3_f}, 2'b00);
    check("R1 after reset u1", {o2_t, o2_f}, 2'b00);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] v;
      logic maj, xr;
      v = k[2:0];
      maj = (int'(v[0]) + int'(v[1]) + int'(v[2])) >= 2;
      xr = v[0] ^ v[1];
      // partly valid: bit 0 left in spacer (R2 encoding)
      in_t = v & 3'b110; in_f = ~v & 3'b110;
      step();
      check("R5 partial valid u0", {o3_t, o3_f}, 2'b00);
      check("R5 partial valid u1", {o2_t, o2_f}, 2'b00);
      in_t = v; in_f = ~v;
      step();
      check("R3 R7 majority", {o3_t, o3_f}, {maj, ~maj});
      check("R3 R7 xor", {o2_t, o2_f}, {xr, ~xr});
      check("R4 exclusive", {1'b0, o3_t & o3_f}, 2'b00);
      // partly back to spacer
      in_t = v & 3'b110; in_f = ~v & 3'b110;
      step();
      check("R6 hold u0", {o3_t, o3_f}, {maj, ~maj});
      check("R6 hold u1", {o2_t, o2_f}, {xr, ~xr});
      in_t = v & 3'b100; in_f = ~v & 3'b100;
      step();
      check("R6 hold deeper u0", {o3_t, o3_f}, {maj, ~maj});
      in_t = '0; in_f = '0;
      step();
      check("R6 spacer u0", {o3_t, o3_f}, 2'b00);
      check("R6 spacer u1", {o2_t, o2_f}, 2'b00);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule